// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This block rearranges the bytes of a 32-bit data word and reports four condition flags about the rearranged value. A 2-bit operation select picks one of four behaviours:

- swap the two bytes inside each 16-bit half;
- reverse the byte order of the whole word;
- exchange the upper and lower halves;
- pass the word through unchanged.

The zero and sign flags describe the result. The carry flag is not arithmetic. It reports zero bytes or zero halves in the result, and the rule for it depends on the operation. The overflow flag always reads zero. An execution pipeline uses the block to service byte-order conversion operations.

A parameter adds a registered output stage. With `REG_OUT = 1`, which is the default, the result and flags appear one clock after the inputs are presented, and reset forces them to zero. With `REG_OUT = 0` the block is purely combinational.

Top module: `swap_unit`

## Requirements
- R1: With `op_sel` = 00, each 16-bit half of the result holds the same half of `src_word` with its two bytes swapped: result[31:24]=src[23:16], result[23:16]=src[31:24], result[15:8]=src[7:0], result[7:0]=src[15:8].
- R2: With `op_sel` = 01, the result is the byte-reversed source: result[31:24]=src[7:0], result[23:16]=src[15:8], result[15:8]=src[23:16], result[7:0]=src[31:24].
- R3: With `op_sel` = 10, result[31:16]=src[15:0] and result[15:0]=src[31:16].
- R4: With `op_sel` = 11, the result equals `src_word` and `flag_carry` is 0.
- R5: `flag_zero` is 1 exactly when all 32 result bits are zero, for every operation.
- R6: `flag_sign` equals result bit 31, for every operation.
- R7: With `op_sel` = 01, `flag_carry` is 1 exactly when at least one of the four result bytes is zero.
- R8: With `op_sel` = 10, `flag_carry` is 1 exactly when result[31:16] or result[15:0] is zero.
- R9: With `op_sel` = 00, `flag_carry` is 1 exactly when result[7:0] is zero.
- R10: `flag_ovf` is always 0.
- R11: With `REG_OUT` = 1, the result and flags for inputs sampled at a rising clock edge appear after that edge. While `rst_n` is low, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset for the output register |
| src_word | input | 32 | Source data word |
| op_sel | input | 2 | Operation select: 00 half byte swap, 01 word byte reverse, 10 half exchange, 11 pass |
| result | output | 32 | Rearranged word |
| flag_zero | output | 1 | Result is all zero |
| flag_sign | output | 1 | Result bit 31 |
| flag_carry | output | 1 | Zero byte or zero half detected, depending on the operation |
| flag_ovf | output | 1 | Overflow, always 0 |

## Verification
With the default registered stage, every result and all four flags are due one rising edge after the operands are presented. The driver changes `src_word` and `op_sel` on the falling edge and queues the expected values. The monitor pops an entry and compares it 1 ns after the next rising edge, so each comparison sees exactly the output of the operands driven half a cycle earlier. The reset values are sampled while reset is still asserted, before any item is queued.

// File: rtl/swap_pkg.sv
package swap_pkg;

    typedef enum logic [1:0] {
        OP_HALF_BSWAP = 2'b00,
        OP_WORD_BREV  = 2'b01,
        OP_HALF_XCHG  = 2'b10,
        OP_PASS       = 2'b11
    } swap_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } swap_flags_t;

endpackage

// File: rtl/swap_datapath.sv
module swap_datapath
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  swap_op_e            op,
    input  logic [DATA_W-1:0]   src,
    output logic [DATA_W-1:0]   res
);
    localparam int NB = DATA_W / 8;
    localparam int NH = DATA_W / 16;
    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] brev_w;
    logic [DATA_W-1:0] hbs_w;
    logic [DATA_W-1:0] xchg_w;

    // Byte reversal across the full word.
    for (genvar b = 0; b < NB; b++) begin : g_brev
        assign brev_w[b*8 +: 8] = src[(NB-1-b)*8 +: 8];
    end

    // Byte swap inside every 16-bit half.
    for (genvar h = 0; h < NH; h++) begin : g_hbs
        assign hbs_w[h*16     +: 8] = src[h*16 + 8 +: 8];
        assign hbs_w[h*16 + 8 +: 8] = src[h*16     +: 8];
    end

    assign xchg_w = {src[HW-1:0], src[DATA_W-1:HW]};

    always_comb begin
        unique case (op)
            OP_HALF_BSWAP: res = hbs_w;
            OP_WORD_BREV:  res = brev_w;
            OP_HALF_XCHG:  res = xchg_w;
            OP_PASS:       res = src;
            default:       res = src;
        endcase
    end

endmodule

// File: rtl/swap_flags.sv
module swap_flags
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  swap_op_e            op,
    input  logic [DATA_W-1:0]   res,
    output swap_flags_t         fl
);
    localparam int NB = DATA_W / 8;
    localparam int HW = DATA_W / 2;

    logic [NB-1:0] byte_zero;
    logic          lo_half_zero;
    logic          hi_half_zero;

    for (genvar b = 0; b < NB; b++) begin : g_bz
        assign byte_zero[b] = (res[b*8 +: 8] == 8'h00);
    end

    assign lo_half_zero = (res[HW-1:0] == '0);
    assign hi_half_zero = (res[DATA_W-1:HW] == '0);

    always_comb begin
        fl    = '0;
        fl.z  = (res == '0);
        fl.s  = res[DATA_W-1];
        unique case (op)
            OP_HALF_BSWAP: fl.cy = byte_zero[0];
            OP_WORD_BREV:  fl.cy = |byte_zero;
            OP_HALF_XCHG:  fl.cy = lo_half_zero | hi_half_zero;
            OP_PASS:       fl.cy = 1'b0;
            default:       fl.cy = 1'b0;
        endcase
    end

endmodule

// File: rtl/swap_unit.sv
module swap_unit
    import swap_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_word,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_carry,
    output logic              flag_ovf
);
    localparam int HW = DATA_W / 2;

    swap_op_e          op_e;
    logic [DATA_W-1:0] dp_res;
    swap_flags_t       fl;

    assign op_e = swap_op_e'(op_sel);

    swap_datapath #(.DATA_W(DATA_W)) u_dp (
        .op  (op_e),
        .src (src_word),
        .res (dp_res)
    );

    swap_flags #(.DATA_W(DATA_W)) u_fl (
        .op  (op_e),
        .res (dp_res),
        .fl  (fl)
    );

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] res_q;
        swap_flags_t       fl_q;
        logic              primed;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q  <= '0;
                fl_q   <= '0;
                primed <= 1'b0;
            end else begin
                res_q  <= dp_res;
                fl_q   <= fl;
                primed <= 1'b1;
            end
        end

        assign result     = res_q;
        assign flag_zero  = fl_q.z;
        assign flag_sign  = fl_q.s;
        assign flag_carry = fl_q.cy;
        assign flag_ovf   = fl_q.ov;

        AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (result == $past(dp_res))); // R11
    end else begin : g_comb
        assign result     = dp_res;
        assign flag_zero  = fl.z;
        assign flag_sign  = fl.s;
        assign flag_carry = fl.cy;
        assign flag_ovf   = fl.ov;
    end

    AST_BREV_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_WORD_BREV) |->
            (dp_res[7:0] == src_word[DATA_W-1 -: 8]) &&
            (dp_res[DATA_W-1 -: 8] == src_word[7:0])); // R2

    AST_XCHG_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_HALF_XCHG) |->
            (dp_res[DATA_W-1:HW] == src_word[HW-1:0])); // R3

    AST_PASS_NOCARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_PASS) |-> (dp_res == src_word) && !fl.cy); // R4

    AST_BSWAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_HALF_BSWAP) |-> (fl.cy == (src_word[15:8] == 8'h00))); // R9

endmodule

// File: tb/tb_swap_unit.sv
module tb_swap_unit;

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        s;
        logic        cy;
        logic [1:0]  op;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_word = '0;
    logic [1:0]  op_sel = '0;
    logic [31:0] result;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    swap_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_word   (src_word),
        .op_sel     (op_sel),
        .result     (result),
        .flag_zero  (flag_zero),
        .flag_sign  (flag_sign),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf)
    );

    function automatic logic [31:0] ref_res(input logic [1:0] op, input logic [31:0] x);
        case (op)
            2'b00:   return ((x & 32'h00ff00ff) << 8) | ((x >> 8) & 32'h00ff00ff);
            2'b01:   return {x[7:0], x[15:8], x[23:16], x[31:24]};
            2'b10:   return (x << 16) | (x >> 16);
            default: return x;
        endcase
    endfunction

    function automatic logic ref_cy(input logic [1:0] op, input logic [31:0] r);
        case (op)
            2'b00:   return (r & 32'h000000ff) == 0;
            2'b01:   return ((r - 32'h01010101) & ~r & 32'h80808080) != 0;
            2'b10:   return ((r & 32'h0000ffff) == 0) || ((r & 32'hffff0000) == 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string res_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string cy_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R9";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] x);
        exp_t e;
        @(negedge clk);
        src_word = x;
        op_sel   = op;
        e.op  = op;
        e.res = ref_res(op, x);
        e.z   = (e.res == 32'h0);
        e.s   = e.res[31];
        e.cy  = ref_cy(op, e.res);
        q.push_back(e);
    endtask

    // Monitor: compares the registered outputs 1 ns after each rising edge (R11 latency).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(res_tag(e.op), result, e.res);
                chk("R5", {31'b0, flag_zero}, {31'b0, e.z});
                chk("R6", {31'b0, flag_sign}, {31'b0, e.s});
                chk(cy_tag(e.op), {31'b0, flag_carry}, {31'b0, e.cy});
                chk("R10", {31'b0, flag_ovf}, 32'h0);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        src_word = 32'hdeadbeef;
        op_sel   = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", result, 32'h0);
        chk("R11", {28'b0, flag_zero, flag_sign, flag_carry, flag_ovf}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int op = 0; op < 4; op++) begin
            drive(op[1:0], 32'h00000000);
            drive(op[1:0], 32'h12345678);
            drive(op[1:0], 32'h80000001);
            drive(op[1:0], 32'hff00ff00);
            drive(op[1:0], 32'h0000ffff);
            for (int b = 0; b < 4; b++) begin
                drive(op[1:0], 32'h11223344 & ~(32'hff << (8 * b)));
            end
        end

        lfsr = 32'hace1f00d;
        for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr[1:0], lfsr ^ (32'h1 << lfsr[7:3]));
        end

        repeat (3) @(posedge clk);
        #1;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule